// File: doc/BRIEF.md
# Wide Free-Running Timer with Coherent Split Reads

A wide up-counter for system-level timekeeping. It starts at zero when reset is released and then only moves forward. No port can load or change it. A 32-bit read port lets software see the count through a set of windows. Each window is a 32-bit slice that begins at a different bit offset, so software picks its time resolution by choosing a window.

The count is wider than the read port, so a complete value takes two reads. Every window read copies the bits above the port width into a capture register at the same clock edge. A later read of the capture register therefore returns the upper bits as they stood at the window read, even if a carry has reached them since. Together the two reads always form one coherent value.

Control inputs set the count rate (half or full clock rate), stop the count for power saving, and freeze it for debug. Reads keep working while the count is stopped. A synchronous application reset clears the count only when a keep input is low. The asynchronous reset always clears it.

Top module: `wide_timer_snap`

## Requirements
- R1: While `rst_n` is low, and at the first read after it rises, the count and the capture register are zero. Counting begins without any further action.
- R2: With `full_rate` low, the count advances by one on every second enabled cycle. The first advance after reset or a clear comes on the second enabled cycle.
- R3: With `full_rate` high, the count advances by one on every enabled cycle.
- R4: A read with `rd_sel` = k, for k in 0..5, returns count bits [4k+31:4k] as they were at the request edge. The data appears on `rd_data` in the next cycle and holds until the next read.
- R5: A read with `rd_sel` in 0..5 copies count bits [55:32] into the capture register at the request edge.
- R6: A read with `rd_sel` = 6 returns the capture register zero-extended to 32 bits and leaves it unchanged. It returns the upper bits from the earlier window read, even after a carry into them.
- R7: A read with `rd_sel` = 7 returns zero and does not change the capture register.
- R8: While `run_en` is low or `halt` is high, the count and the rate phase hold their values, and reads still return data.
- R9: A cycle with `app_rst` high and `app_keep` low clears the count, the capture register and the rate phase.
- R10: A cycle with `app_rst` high and `app_keep` high changes nothing.
- R11: After the all-ones value the count wraps to zero and keeps counting, with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; always clears |
| app_rst | input | 1 | Synchronous application reset request |
| app_keep | input | 1 | When high, the count and the capture register survive `app_rst` |
| run_en | input | 1 | Count enable (low = power-save stop) |
| halt | input | 1 | Debug freeze of the count |
| full_rate | input | 1 | 1 = count every enabled cycle, 0 = every second enabled cycle |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | 0..5 window, 6 capture register, 7 reserved (zero) |
| rd_data | output | 32 | Registered read data, valid the cycle after the request |

## Verification
The hard case is a carry out of the low 32 bits that falls between the window read and the capture read. At 56 bits this would take billions of cycles. The bench therefore adds a second instance with a 12-bit count, an 8-bit port, one-bit window steps and five windows. On that instance it aims a window read at the value just before the carry (0x0FF) and the capture read one cycle later. The same small instance also walks through the wrap from all ones to zero. A reference model follows both counts and the rate phase from the control inputs, so stop, freeze, clear and keep sequences can be checked at any cycle.

// File: rtl/wts_pkg.sv
package wts_pkg;

  // Rate-control inputs grouped for the prescaler.
  typedef struct packed {
    logic run;
    logic halt;
    logic full;
  } wts_rate_t;

  function automatic int unsigned wts_sel_w(int unsigned n_win);
    return $clog2(n_win + 1);
  endfunction

endpackage

// File: rtl/wts_tick.sv
module wts_tick
  import wts_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wts_rate_t rate,
  input  logic      clr,
  output logic      tick
);

  logic ph_q, ph_d;
  logic active;

  assign active = rate.run & ~rate.halt;

  always_comb begin
    ph_d = ph_q;
    tick = 1'b0;
    if (clr) begin
      ph_d = 1'b0;
    end else if (active) begin
      if (rate.full) begin
        tick = 1'b1;
        ph_d = 1'b0;
      end else begin
        tick = ph_q;
        ph_d = ~ph_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/wts_count.sv
module wts_count #(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | tick;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wts_read.sv
module wts_read #(
  parameter int CNT_W    = 56,
  parameter int DATA_W   = 32,
  parameter int WIN_N    = 6,
  parameter int WIN_STEP = 4,
  parameter int SEL_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          cnt,
  input  logic                      clr,
  input  logic                      rd_en,
  input  logic [SEL_W-1:0]          rd_sel,
  output logic [DATA_W-1:0]         rd_data,
  output logic [CNT_W-DATA_W-1:0]   cap
);

  localparam int CAP_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] win [WIN_N];
  logic [CAP_W-1:0]  cap_q, cap_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              win_hit;
  logic              cap_en;

  for (genvar k = 0; k < WIN_N; k++) begin : g_win
    assign win[k] = cnt[k*WIN_STEP +: DATA_W];
  end

  always_comb begin
    rd_d    = '0;
    win_hit = 1'b0;
    for (int k = 0; k < WIN_N; k++) begin
      if (rd_sel == SEL_W'(k)) begin
        rd_d    = win[k];
        win_hit = 1'b1;
      end
    end
    if (rd_sel == SEL_W'(WIN_N)) rd_d = DATA_W'(cap_q);
  end

  assign cap_en = clr | (rd_en & win_hit);

  always_comb begin
    if (clr) cap_d = '0;
    else     cap_d = cnt[CNT_W-1:DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign cap     = cap_q;

endmodule

// File: rtl/wide_timer_snap.sv
module wide_timer_snap
  import wts_pkg::*;
#(
  parameter int CNT_W    = 56,
  parameter int DATA_W   = 32,
  parameter int WIN_N    = 6,
  parameter int WIN_STEP = 4,
  localparam int SEL_W   = wts_sel_w(WIN_N),
  localparam int CAP_W   = CNT_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_rst,
  input  logic              app_keep,
  input  logic              run_en,
  input  logic              halt,
  input  logic              full_rate,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);

  logic             app_clr;
  logic             tick;
  wts_rate_t        rate;
  logic [CNT_W-1:0] cnt_q;
  logic [CAP_W-1:0] cap_q;

  assign app_clr = app_rst & ~app_keep;
  assign rate    = '{run: run_en, halt: halt, full: full_rate};

  wts_tick i_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .rate  (rate),
    .clr   (app_clr),
    .tick  (tick)
  );

  wts_count #(.CNT_W(CNT_W)) i_count (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clr   (app_clr),
    .cnt   (cnt_q)
  );

  wts_read #(
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .WIN_N    (WIN_N),
    .WIN_STEP (WIN_STEP),
    .SEL_W    (SEL_W)
  ) i_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_q),
    .clr     (app_clr),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .cap     (cap_q)
  );

endmodule

// File: rtl/wts_chk.sv
module wts_chk #(
  parameter int CNT_W  = 56,
  parameter int DATA_W = 32,
  parameter int WIN_N  = 6,
  parameter int SEL_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    app_rst,
  input logic                    app_keep,
  input logic                    run_en,
  input logic                    halt,
  input logic                    full_rate,
  input logic                    rd_en,
  input logic [SEL_W-1:0]        rd_sel,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [CNT_W-DATA_W-1:0] cap_q
);

  logic clr;
  assign clr = app_rst & ~app_keep;

  // R9
  app_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && cap_q == '0));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (!run_en || halt)) |=> $stable(cnt_q));

  // R3
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && run_en && !halt && full_rate) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && rd_en && rd_sel < SEL_W'(WIN_N)) |=> cap_q == $past(cnt_q[CNT_W-1:DATA_W]));

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && rd_en && rd_sel >= SEL_W'(WIN_N)) |=> $stable(cap_q));

endmodule

bind wide_timer_snap wts_chk #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .WIN_N  (WIN_N),
  .SEL_W  (SEL_W)
) i_wts_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .app_rst   (app_rst),
  .app_keep  (app_keep),
  .run_en    (run_en),
  .halt      (halt),
  .full_rate (full_rate),
  .rd_en     (rd_en),
  .rd_sel    (rd_sel),
  .cnt_q     (cnt_q),
  .cap_q     (cap_q)
);

// File: tb/test_wide_timer_snap.sv
`timescale 1ns/1ps
module test_wide_timer_snap;

  localparam int BW = 56, BD = 32, BN = 6, BS = 4;
  localparam int SW = 12, SD = 8,  SN = 5, SS = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, app_rst, app_keep, run_en, halt, full_rate;
  logic rd_en_b, rd_en_s;
  logic [2:0] rd_sel_b, rd_sel_s;
  logic [BD-1:0] rd_data_b;
  logic [SD-1:0] rd_data_s;

  wide_timer_snap i_wide_timer_snap (
    .clk(clk), .rst_n(rst_n), .app_rst(app_rst), .app_keep(app_keep),
    .run_en(run_en), .halt(halt), .full_rate(full_rate),
    .rd_en(rd_en_b), .rd_sel(rd_sel_b), .rd_data(rd_data_b));

  wide_timer_snap #(.CNT_W(SW), .DATA_W(SD), .WIN_N(SN), .WIN_STEP(SS)) i_wide_timer_snap_small (
    .clk(clk), .rst_n(rst_n), .app_rst(app_rst), .app_keep(app_keep),
    .run_en(run_en), .halt(halt), .full_rate(full_rate),
    .rd_en(rd_en_s), .rd_sel(rd_sel_s), .rd_data(rd_data_s));

  // Reference model, built from the requirements
  logic [BW-1:0]    m_big;
  logic [SW-1:0]    m_sml;
  logic             m_ph;
  logic [BW-BD-1:0] m_cap_b;
  logic [SW-SD-1:0] m_cap_s;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_big <= '0; m_sml <= '0; m_ph <= 1'b0; m_cap_b <= '0; m_cap_s <= '0;
    end else if (app_rst && !app_keep) begin
      m_big <= '0; m_sml <= '0; m_ph <= 1'b0; m_cap_b <= '0; m_cap_s <= '0;
    end else begin
      if (run_en && !halt) begin
        if (full_rate || m_ph) begin
          m_big <= m_big + 1'b1;
          m_sml <= m_sml + 1'b1;
        end
        m_ph <= full_rate ? 1'b0 : ~m_ph;
      end
      if (rd_en_b && rd_sel_b < 3'(BN)) m_cap_b <= m_big[BW-1:BD];
      if (rd_en_s && rd_sel_s < 3'(SN)) m_cap_s <= m_sml[SW-1:SD];
    end
  end

  typedef struct {
    int          due;
    logic [31:0] exp;
    bit          sml;
    string       req;
  } sb_item_t;

  sb_item_t sb[$];
  int n_run  = 0;
  int n_fail = 0;

  function automatic logic [31:0] exp_val(bit sml, int sel);
    if (!sml) begin
      if (sel < BN)       return 32'(m_big >> (sel * BS));
      else if (sel == BN) return 32'(m_cap_b);
      else                return 32'h0;
    end else begin
      if (sel < SN)       return 32'(8'(m_sml >> (sel * SS)));
      else if (sel == SN) return 32'(m_cap_s);
      else                return 32'h0;
    end
  endfunction

  // Driver: called at a negative edge, one read per call
  task automatic rd(bit sml, int sel, string req);
    sb_item_t it;
    it.due = cyc + 1;
    it.exp = exp_val(sml, sel);
    it.sml = sml;
    it.req = req;
    sb.push_back(it);
    if (sml) begin rd_en_s = 1'b1; rd_sel_s = 3'(sel); end
    else     begin rd_en_b = 1'b1; rd_sel_b = 3'(sel); end
    @(negedge clk);
    rd_en_s = 1'b0; rd_en_b = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      sb_item_t it;
      logic [31:0] got;
      it  = sb.pop_front();
      got = it.sml ? 32'(rd_data_s) : rd_data_b;
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_sml(logic [SW-1:0] v);
    while (m_sml != v) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; app_rst = 1'b0; app_keep = 1'b0;
    run_en = 1'b1; halt = 1'b0; full_rate = 1'b0;
    rd_en_b = 1'b0; rd_en_s = 1'b0; rd_sel_b = '0; rd_sel_s = '0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 0, "R1");
    rd(0, BN, "R1");
    // R2 half rate
    idle(7);
    rd(0, 0, "R2");
    rd(0, 0, "R2");
    rd(0, 0, "R2");
    // R3 / R4 full rate, every window
    full_rate = 1'b1;
    idle(5);
    rd(0, 0, "R3");
    rd(0, 0, "R3");
    for (int k = 0; k < BN; k++) rd(0, k, "R4");
    // R5 / R6 capture read
    rd(0, BN, "R5");
    rd(0, BN, "R6");
    // R7 reserved select
    rd(0, 7, "R7");
    rd(0, BN, "R7");
    // R8 freeze and stop
    halt = 1'b1;
    idle(2);
    rd(0, 0, "R8");
    rd(0, 1, "R8");
    halt = 1'b0; run_en = 1'b0; full_rate = 1'b0;
    idle(3);
    rd(0, 0, "R8");
    run_en = 1'b1;
    idle(3);
    rd(0, 0, "R8");
    // R10 keep
    app_keep = 1'b1; app_rst = 1'b1;
    @(negedge clk);
    app_rst = 1'b0;
    rd(0, 0, "R10");
    rd(0, BN, "R10");
    // R9 clear
    app_keep = 1'b0; app_rst = 1'b1;
    @(negedge clk);
    app_rst = 1'b0;
    rd(0, 0, "R9");
    rd(0, BN, "R9");
    idle(4);
    rd(0, 0, "R9");
    // R6 carry between window read and capture read (small instance)
    full_rate = 1'b1;
    wait_sml(12'h0FF);
    rd(1, 0, "R6");
    rd(1, SN, "R6");
    rd(1, 6, "R7");
    // R11 wrap
    wait_sml(12'hFFF);
    rd(1, 0, "R11");
    rd(1, 0, "R11");
    rd(1, 4, "R11");
    rd(1, SN, "R11");
    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule